// File: doc/BRIEF.md
# Variable Page-Size Translation Buffer

The block is a fully associative, unified address translation buffer with a default of 64 entries. Software composes an entry in three staging registers (a high word carrying the page number and address-space identifier, a low word carrying the physical page, size, protection and cache flags, and a small auxiliary word carrying a space attribute and a timing-control bit). It selects the destination slot through a replace-counter field in a control word, then pulses a load strobe. The entry is built from the staged fields and written into the slot named by the counter.

A lookup presents a 32-bit virtual address and an 8-bit address-space identifier. Every valid entry compares the address against its own range. The size of that range is set by the entry's own page size of 1 KB, 4 KB, 64 KB or 1 MB. The combined result is registered one clock later as exactly one of hit, miss or multiple-hit. On a hit the block also returns the slot index and the stored attributes of the matching entry.

Top module: `varpage_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid, the replace counter is 0 and all result outputs are 0; a lookup then reports a miss.
- R2: Writing the high staging word (select code 0) supplies the entry's address-space identifier from bits 7:0 and its virtual page number from bits 31:10.
- R3: Writing the low staging word (select code 1) supplies the valid bit from bit 8, the physical page number from bits 28:10, the protection code from bits 6:5, and the flags cacheable bit 3, dirty bit 2, shared bit 1 and write-through bit 0. A hit returns these fields.
- R4: The page-size code is {low bit 7, low bit 4}; codes 0, 1, 2 and 3 mean 1 KB, 4 KB, 64 KB and 1 MB. An entry matches an address from (page number << 10) with the low log2(size) bits cleared up to that base plus the size minus 1, both ends inclusive.
- R5: Writing the auxiliary word (select code 2) keeps only bits 3:0; a hit returns bits 2:0 as the space attribute and bit 3 as the timing-control bit.
- R6: Writing the control word (select code 3) sets the replace counter from bits 15:10. A load strobe writes the staged entry into the slot the counter names and replaces any earlier content of that slot. The counter does not change by itself.
- R7: Entries whose valid bit is 0 never match.
- R8: When the identifier check is enabled, an entry matches only if its identifier equals the lookup identifier or its shared flag is 1. When the check is disabled, identifiers are ignored.
- R9: If two or more entries match, the result is multiple-hit, not hit, and the index and attributes read 0.
- R10: If no entry matches, the result is miss, and the index and attributes read 0.
- R11: A result appears with res_valid high in the cycle after each lookup request, back-to-back requests included. Exactly one of hit, miss and multiple-hit is then 1. With no request, all three flags are 0.
- R12: A load strobe in the same cycle as a lookup affects only later lookups; the concurrent lookup sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Staging/control word write strobe |
| cfg_sel | input | 2 | Word select: 0 high, 1 low, 2 auxiliary, 3 control |
| cfg_wdata | input | 32 | Write data |
| load_en | input | 1 | Load staged entry into the counter-selected slot |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_asid_en | input | 1 | Enable identifier comparison |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_hit | output | 1 | Exactly one entry matched |
| res_miss | output | 1 | No entry matched |
| res_multi | output | 1 | More than one entry matched |
| res_index | output | 6 | Slot of the matching entry, 0 unless hit |
| res_ppn | output | 19 | Physical page number of the hit |
| res_size | output | 2 | Page-size code of the hit |
| res_prot | output | 2 | Protection code of the hit |
| res_cacheable | output | 1 | Cacheable flag of the hit |
| res_dirty | output | 1 | Dirty flag of the hit |
| res_shared | output | 1 | Shared flag of the hit |
| res_wthru | output | 1 | Write-through flag of the hit |
| res_space | output | 3 | Space attribute of the hit |
| res_tmg | output | 1 | Timing-control bit of the hit |

## Verification
An entry load and a lookup can fall in the same cycle. The bench provokes this by raising the load strobe and the lookup request together, with the address inside the range of the entry being loaded. The concurrent result must be a miss, and a lookup one cycle later must hit that slot. Overlapping ranges are provoked separately by loading a second entry that covers an existing page, which the bench judges as a multiple-hit with zeroed index.

// File: rtl/vptlb_pkg.sv
package vptlb_pkg;

    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int VPN_W   = 22;
    localparam int PPN_W   = 19;
    localparam int CTR_W   = 6;
    localparam int PG_LSB  = 10;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        SEL_HI  = 2'd0,
        SEL_LO  = 2'd1,
        SEL_AUX = 2'd2,
        SEL_CTL = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        pg_size_e         size;
        logic [1:0]       prot;
        logic             cacheable;
        logic             dirty;
        logic             shared;
        logic             wthru;
        logic [2:0]       space;
        logic             tmg;
    } tlb_attr_t;

    typedef struct packed {
        logic              valid;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        tlb_attr_t         attr;
    } tlb_ent_t;

    // Bits that survive the page-size alignment of an address.
    function automatic logic [VA_W-1:0] page_mask(input pg_size_e sz);
        logic [VA_W-1:0] m;
        case (sz)
            PG_1K:   m = ~32'h0000_03FF;
            PG_4K:   m = ~32'h0000_0FFF;
            PG_64K:  m = ~32'h0000_FFFF;
            default: m = ~32'h000F_FFFF;
        endcase
        return m;
    endfunction

    function automatic tlb_ent_t build_entry(input logic [31:0] hi,
                                             input logic [31:0] lo,
                                             input logic [3:0]  aux);
        tlb_ent_t e;
        e.valid          = lo[8];
        e.asid           = hi[7:0];
        e.vpn            = hi[31:10];
        e.attr.ppn       = lo[28:10];
        e.attr.size      = pg_size_e'({lo[7], lo[4]});
        e.attr.prot      = lo[6:5];
        e.attr.cacheable = lo[3];
        e.attr.dirty     = lo[2];
        e.attr.shared    = lo[1];
        e.attr.wthru     = lo[0];
        e.attr.space     = aux[2:0];
        e.attr.tmg       = aux[3];
        return e;
    endfunction

endpackage

// File: rtl/vptlb_stage.sv
module vptlb_stage
    import vptlb_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  cfg_sel_e         cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output tlb_ent_t         new_entry,
    output logic [IDX_W-1:0] wr_idx
);

    logic [31:0]      hi_q;
    logic [31:0]      lo_q;
    logic [3:0]       aux_q;
    logic [CTR_W-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            aux_q <= '0;
            ctr_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_HI:  hi_q  <= cfg_wdata;
                SEL_LO:  lo_q  <= cfg_wdata;
                SEL_AUX: aux_q <= cfg_wdata[3:0];
                default: ctr_q <= cfg_wdata[PG_LSB +: CTR_W];
            endcase
        end
    end

    assign new_entry = build_entry(hi_q, lo_q, aux_q);
    assign wr_idx    = ctr_q[IDX_W-1:0];

endmodule

// File: rtl/vptlb_store.sv
module vptlb_store
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          new_entry,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_asid_en,
    output logic [ENTRIES-1:0] match_vec,
    output tlb_ent_t          ent_o [ENTRIES]
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_ent_t        ent_q;
        logic [VA_W-1:0] mask;
        logic [VA_W-1:0] base;
        logic            range_ok;
        logic            asid_ok;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (load_en && (wr_idx == IDX_W'(g))) begin
                ent_q <= new_entry;
            end
        end

        always_comb begin
            mask     = page_mask(ent_q.attr.size);
            base     = {ent_q.vpn, {PG_LSB{1'b0}}} & mask;
            range_ok = ((lk_vaddr & mask) == base);
            asid_ok  = !lk_asid_en || ent_q.attr.shared || (ent_q.asid == lk_asid);
        end

        assign match_vec[g] = ent_q.valid && range_ok && asid_ok;
        assign ent_o[g]     = ent_q;
    end

endmodule

// File: rtl/vptlb_resolve.sv
module vptlb_resolve
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] match_vec,
    input  tlb_ent_t           ent_i [ENTRIES],
    output logic               hit,
    output logic               miss,
    output logic               multi,
    output logic [IDX_W-1:0]   idx,
    output tlb_attr_t          attr
);

    logic            any;
    logic            many;
    logic [IDX_W-1:0] first_idx;
    tlb_attr_t       or_attr;

    always_comb begin
        any  = |match_vec;
        many = |(match_vec & (match_vec - ENTRIES'(1)));
        first_idx = '0;
        or_attr   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) first_idx = IDX_W'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) or_attr = or_attr | ent_i[i].attr;
        end
        hit   = any && !many;
        miss  = !any;
        multi = many;
        idx   = hit ? first_idx : '0;
        attr  = hit ? or_attr : '0;
    end

endmodule

// File: rtl/varpage_tlb.sv
module varpage_tlb
    import vptlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              load_en,
    input  logic              lk_req,
    input  logic [31:0]       lk_vaddr,
    input  logic [7:0]        lk_asid,
    input  logic              lk_asid_en,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_multi,
    output logic [IDX_W-1:0]  res_index,
    output logic [18:0]       res_ppn,
    output logic [1:0]        res_size,
    output logic [1:0]        res_prot,
    output logic              res_cacheable,
    output logic              res_dirty,
    output logic              res_shared,
    output logic              res_wthru,
    output logic [2:0]        res_space,
    output logic              res_tmg
);

    tlb_ent_t           new_entry;
    logic [IDX_W-1:0]   wr_idx;
    logic [ENTRIES-1:0] match_vec;
    tlb_ent_t           ents [ENTRIES];
    logic               c_hit, c_miss, c_multi;
    logic [IDX_W-1:0]   c_idx;
    tlb_attr_t          c_attr;
    tlb_attr_t          r_attr;

    vptlb_stage #(.IDX_W(IDX_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel_e'(cfg_sel)),
        .cfg_wdata (cfg_wdata),
        .new_entry (new_entry),
        .wr_idx    (wr_idx)
    );

    vptlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .wr_idx     (wr_idx),
        .new_entry  (new_entry),
        .lk_vaddr   (lk_vaddr),
        .lk_asid    (lk_asid),
        .lk_asid_en (lk_asid_en),
        .match_vec  (match_vec),
        .ent_o      (ents)
    );

    vptlb_resolve #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_resolve (
        .match_vec (match_vec),
        .ent_i     (ents),
        .hit       (c_hit),
        .miss      (c_miss),
        .multi     (c_multi),
        .idx       (c_idx),
        .attr      (c_attr)
    );

    always_ff @(posedge clk) begin
        if (rst || !lk_req) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_multi <= 1'b0;
            res_index <= '0;
            r_attr    <= '0;
        end else begin
            res_valid <= 1'b1;
            res_hit   <= c_hit;
            res_miss  <= c_miss;
            res_multi <= c_multi;
            res_index <= c_idx;
            r_attr    <= c_attr;
        end
    end

    assign res_ppn       = r_attr.ppn;
    assign res_size      = r_attr.size;
    assign res_prot      = r_attr.prot;
    assign res_cacheable = r_attr.cacheable;
    assign res_dirty     = r_attr.dirty;
    assign res_shared    = r_attr.shared;
    assign res_wthru     = r_attr.wthru;
    assign res_space     = r_attr.space;
    assign res_tmg       = r_attr.tmg;

endmodule

// File: rtl/vptlb_chk.sv
module vptlb_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_req,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_multi,
    input logic [IDX_W-1:0] res_index,
    input logic [18:0]      res_ppn
);

    assert_valid_after_req_R11: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> res_valid);

    assert_no_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !res_valid);

    assert_one_flag_R11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones({res_hit, res_miss, res_multi}) == 1));

    assert_quiet_flags_R11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_hit || res_miss || res_multi));

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (res_index == '0 && res_ppn == '0));

    assert_multi_zero_R9: assert property (@(posedge clk) disable iff (rst)
        res_multi |-> (res_index == '0 && res_ppn == '0));

endmodule

bind varpage_tlb vptlb_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_multi (res_multi),
    .res_index (res_index),
    .res_ppn   (res_ppn)
);

// File: tb/varpage_tlb_test.sv
module varpage_tlb_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        load_en = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_asid_en = 1'b0;
    logic        res_valid, res_hit, res_miss, res_multi;
    logic [5:0]  res_index;
    logic [18:0] res_ppn;
    logic [1:0]  res_size, res_prot;
    logic        res_cacheable, res_dirty, res_shared, res_wthru, res_tmg;
    logic [2:0]  res_space;

    always #5 clk = ~clk;

    varpage_tlb uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .load_en(load_en), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_asid_en(lk_asid_en), .res_valid(res_valid), .res_hit(res_hit),
        .res_miss(res_miss), .res_multi(res_multi), .res_index(res_index),
        .res_ppn(res_ppn), .res_size(res_size), .res_prot(res_prot),
        .res_cacheable(res_cacheable), .res_dirty(res_dirty), .res_shared(res_shared),
        .res_wthru(res_wthru), .res_space(res_space), .res_tmg(res_tmg)
    );

    typedef struct {
        string       tag;
        logic [39:0] vec;
    } exp_t;

    exp_t        sb [$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic        mon_on = 1'b0;

    logic [31:0] m_hi [64];
    logic [31:0] m_lo [64];
    logic [31:0] m_aux [64];
    logic [31:0] s_hi = '0, s_lo = '0, s_aux = '0;
    logic [5:0]  s_ctr = '0;

    function automatic logic [31:0] mk_lo(input logic v, input logic [18:0] ppn,
                                          input logic [1:0] sz, input logic [1:0] prot,
                                          input logic [3:0] cdsw);
        return {3'b000, ppn, 1'b0, v, sz[1], prot, sz[0], cdsw};
    endfunction

    function automatic logic [39:0] model(input logic [31:0] va, input logic [7:0] as,
                                          input logic aen);
        int n = 0;
        int k = 0;
        for (int i = 0; i < 64; i++) begin
            logic [1:0]  sz;
            logic [31:0] msk;
            sz = {m_lo[i][7], m_lo[i][4]};
            case (sz)
                2'd0: msk = 32'hFFFF_FC00;
                2'd1: msk = 32'hFFFF_F000;
                2'd2: msk = 32'hFFFF_0000;
                default: msk = 32'hFFF0_0000;
            endcase
            if (m_lo[i][8] && ((va & msk) == ({m_hi[i][31:10], 10'b0} & msk)) &&
                (!aen || m_lo[i][1] || (m_hi[i][7:0] == as))) begin
                n++;
                k = i;
            end
        end
        if (n == 1)
            return {3'b100, 6'(k), m_lo[k][28:10], m_lo[k][7], m_lo[k][4],
                    m_lo[k][6:5], m_lo[k][3:0], m_aux[k][2:0], m_aux[k][3]};
        else if (n == 0)
            return {3'b010, 37'b0};
        else
            return {3'b001, 37'b0};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        case (sel)
            2'd0: s_hi = d;
            2'd1: s_lo = d;
            2'd2: s_aux = d & 32'hF;
            default: s_ctr = d[15:10];
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic stage(input int idx, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] aux);
        wr(2'd3, 32'(idx) << 10);
        wr(2'd0, hi);
        wr(2'd1, lo);
        wr(2'd2, aux);
    endtask

    task automatic do_load();
        load_en = 1'b1;
        m_hi[s_ctr] = s_hi; m_lo[s_ctr] = s_lo; m_aux[s_ctr] = s_aux;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] as, input logic aen,
                        input string tag);
        exp_t e;
        e.tag = tag;
        e.vec = model(va, as, aen);
        sb.push_back(e);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = as; lk_asid_en = aen;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic look_and_load(input logic [31:0] va, input logic [7:0] as,
                                 input logic aen, input string tag);
        exp_t e;
        e.tag = tag;
        e.vec = model(va, as, aen);
        sb.push_back(e);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = as; lk_asid_en = aen;
        load_en = 1'b1;
        m_hi[s_ctr] = s_hi; m_lo[s_ctr] = s_lo; m_aux[s_ctr] = s_aux;
        @(negedge clk);
        lk_req = 1'b0;
        load_en = 1'b0;
    endtask

    // Monitor: pops expected results as the design presents them.
    always @(negedge clk) begin
        if (mon_on) begin
            if (res_valid) begin
                logic [39:0] act;
                act = {res_hit, res_miss, res_multi, res_index, res_ppn, res_size, res_prot,
                       res_cacheable, res_dirty, res_shared, res_wthru, res_space, res_tmg};
                n_vec++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R11 unexpected result: actual %h expected none", act);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (act !== e.vec) begin
                        n_bad++;
                        $display("FAIL %s: actual %h expected %h", e.tag, act, e.vec);
                    end
                end
            end else if (res_hit || res_miss || res_multi) begin
                n_vec++;
                n_bad++;
                $display("FAIL R11 flags without valid: actual %b%b%b expected 000",
                         res_hit, res_miss, res_multi);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_hi[i] = '0; m_lo[i] = '0; m_aux[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        n_vec++;
        if (res_valid || res_hit || res_miss || res_multi || res_index != 0 || res_ppn != 0) begin
            n_bad++;
            $display("FAIL R1 reset outputs: actual %b%b%b%b idx %0d expected 0000 idx 0",
                     res_valid, res_hit, res_miss, res_multi, res_index);
        end
        mon_on = 1'b1;
        look(32'h1234_5ABC, 8'h11, 1'b1, "R1 R10 lookup after reset misses");

        // R2 R3 R5 R6: 4 KB entry in slot 5, auxiliary word with junk upper bits
        stage(5, 32'h1234_5011, mk_lo(1'b1, 19'h45678, 2'd1, 2'd2, 4'b1001), 32'h0000_00FD);
        do_load();
        look(32'h1234_5ABC, 8'h11, 1'b1, "R2 R3 R5 R6 hit slot 5 fields");
        look(32'h1234_5000, 8'h11, 1'b1, "R4 4K range start");
        look(32'h1234_5FFF, 8'h11, 1'b1, "R4 4K range end");
        look(32'h1234_6000, 8'h11, 1'b1, "R4 4K end plus one misses");

        // R4: 1 KB entry
        stage(6, 32'h0000_0411, mk_lo(1'b1, 19'h00123, 2'd0, 2'd1, 4'b0110), 32'h3);
        do_load();
        look(32'h0000_07FF, 8'h11, 1'b1, "R4 1K range end");
        look(32'h0000_0800, 8'h11, 1'b1, "R4 1K end plus one misses");

        // R4: 64 KB entry whose page number carries bits below the page size
        stage(7, 32'h2003_4C11, mk_lo(1'b1, 19'h7FFFF, 2'd2, 2'd3, 4'b1111), 32'h8);
        do_load();
        look(32'h2003_0000, 8'h11, 1'b1, "R4 64K aligned start");
        look(32'h2003_FFFF, 8'h11, 1'b1, "R4 64K range end");
        look(32'h2004_0000, 8'h11, 1'b1, "R4 64K end plus one misses");

        // R4: 1 MB entry
        stage(8, 32'h400A_BC11, mk_lo(1'b1, 19'h1_0000, 2'd3, 2'd0, 4'b0100), 32'h1);
        do_load();
        look(32'h400F_FFFF, 8'h11, 1'b1, "R4 1M range end");
        look(32'h4010_0000, 8'h11, 1'b1, "R4 1M end plus one misses");
        look(32'h3FFF_FFFF, 8'h11, 1'b1, "R4 1M start minus one misses");

        // R8: identifier checks and the shared flag
        look(32'h1234_5100, 8'h22, 1'b1, "R8 identifier mismatch misses");
        look(32'h1234_5100, 8'h22, 1'b0, "R8 identifier check disabled hits");
        stage(9, 32'h5000_0033, mk_lo(1'b1, 19'h00999, 2'd1, 2'd1, 4'b0010), 32'h2);
        do_load();
        look(32'h5000_0040, 8'h44, 1'b1, "R8 shared entry ignores identifier");

        // R7: entry with valid bit clear
        stage(10, 32'h6000_0011, mk_lo(1'b0, 19'h00555, 2'd1, 2'd0, 4'b0000), 32'h0);
        do_load();
        look(32'h6000_0010, 8'h11, 1'b1, "R7 invalid entry never matches");

        // R9: overlapping entry in slot 11
        stage(11, 32'h1234_5011, mk_lo(1'b1, 19'h00777, 2'd1, 2'd0, 4'b0000), 32'h0);
        do_load();
        look(32'h1234_5100, 8'h11, 1'b1, "R9 two matches give multiple-hit");

        // R6: overwrite slot 11 with an invalid entry, counter kept at 11
        wr(2'd1, mk_lo(1'b0, 19'h00777, 2'd1, 2'd0, 4'b0000));
        do_load();
        look(32'h1234_5100, 8'h11, 1'b1, "R6 slot overwritten, single hit again");

        // R12: load and lookup of the same page in one cycle
        stage(12, 32'h7000_0011, mk_lo(1'b1, 19'h00ABC, 2'd1, 2'd2, 4'b1000), 32'h5);
        look_and_load(32'h7000_0010, 8'h11, 1'b1, "R12 concurrent lookup sees old contents");
        look(32'h7000_0010, 8'h11, 1'b1, "R12 following lookup sees new entry");

        // R11: back-to-back lookups in consecutive cycles
        look(32'h0000_0500, 8'h11, 1'b1, "R11 back-to-back first");
        look(32'h2003_8000, 8'h11, 1'b1, "R11 back-to-back second");
        look(32'h9000_0000, 8'h11, 1'b1, "R11 back-to-back third");

        repeat (4) @(negedge clk);
        n_vec++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R11 results missing: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end

endmodule